// File: doc/BRIEF.md
# Strobe-Driven FIFO With Retransmit

This block is a first-in first-out buffer of 9-bit words. It is controlled by active-low write and read strobes, in the way an asynchronous buffer chip is controlled, but it is built in a single system clock domain.

Both strobe pins pass through synchronizers. A transfer takes effect when the synchronized strobe goes from low to high. While the read strobe is held low and data is stored, the oldest word is shown on `dout` and `dout_vld` is high. `dout_vld` takes the place of a three-state output enable. Three active-low flags report the fill level:
- empty,
- full,
- more than half full.

An active-low retransmit input moves the read position back to the first location and leaves the write position alone, so the stored words can be read again.

A state machine with three states sets the flags:
- `ST_EMPTY`: no word is stored.
- `ST_HOLD`: between one word and one less than full.
- `ST_FULL`: every location holds a word.

The state moves as follows:
- **fill** (`ST_EMPTY` to `ST_HOLD`): a write is accepted, or a rewind restores the words.
- **drain** (`ST_HOLD` to `ST_EMPTY`): the last word is read.
- **top** (`ST_HOLD` to `ST_FULL`): the last free location is written.
- **release** (`ST_FULL` to `ST_HOLD`): a word is read.
- **rewind**: retransmit sets the count from the write position, and a full buffer stays full.
- **reset**: reset enters `ST_EMPTY` from any state.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_vld`=0, and both positions return to location zero.
- R2: A rising edge on `wr_n` stores the word on `din`. `din` must be held until the edge has been synchronized. Flags reflect the write within three clock cycles.
- R3: Words leave the buffer in the order they were written. While `dout_vld` is high, `dout` carries the oldest stored word.
- R4: A rising edge on `rd_n` removes the oldest word only while `empty_n` is 1. A read strobe on an empty buffer is ignored: the buffer stays empty, and the next word written is the first word read.
- R5: A write strobe while `full_n` is 0 is ignored. The flag stays low, and no stored word is overwritten.
- R6: `half_n` is 0 exactly when more than DEPTH/2 words are stored. At DEPTH/2 words it is 1, and at DEPTH/2+1 words it is 0.
- R7: `full_n` goes to 0 when DEPTH words are stored, and only then.
- R8: `dout_vld` is 1 exactly while the synchronized `rd_n` is low and the buffer is not empty.
- R9: Read flow-through. If `rd_n` is held low on an empty buffer and one word is written, `empty_n` rises and the word appears on `dout` with `dout_vld`=1. When `rd_n` rises, the word is consumed, `empty_n` returns to 0 and `dout_vld` drops.
- R10: Write flow-through. If `wr_n` is held low on a full buffer and one word is read, `full_n` rises. The held write completes when `wr_n` rises, and `full_n` returns to 0.
- R11: While `rt_n` is low, the read position returns to location zero and the write position is kept. The words written since reset are then read again from the first one.
- R12: A read and a write that both take effect in the same clock cycle leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_n | input | 1 | Active-low write strobe; its rising edge stores `din` |
| din | input | 9 | Write data |
| rd_n | input | 1 | Active-low read strobe; its rising edge consumes a word |
| rt_n | input | 1 | Active-low retransmit |
| dout | output | 9 | Oldest stored word |
| dout_vld | output | 1 | `dout` is being driven (stands in for the output enable) |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| half_n | output | 1 | Low when more than half full |

## Verification
The main transfer path is tried with four patterns, and each one separates a different class of fault:
- **Plain write-then-read bursts** show pointer ordering.
- **A fill to the half and full boundaries followed by a complete drain** separates off-by-one errors in the count compare from wrap errors in the pointers.
- **Strobes on an empty buffer and on a full buffer** show whether a blocked strobe is really ignored or silently moves a pointer.
- **Both strobes rising together** show whether same-cycle transfers are netted correctly, rather than one of them being dropped.

Held-strobe flow-through patterns and a retransmit after a partial read cover the flag pulses and the rewind.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] sh;

    // Idle level of every strobe is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], pin};
    end

    assign level = sh[STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lvl,
    input  logic          rd_lvl,
    input  logic          rt_lvl,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n,
    output logic          dout_vld
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    occ_state_e    st, st_n;
    logic [AW-1:0] wp, rp, wp_n, rp_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          wr_prev, rd_prev;
    logic          wr_rise, rd_rise, rt_act;
    logic          do_wr, do_rd;

    assign wr_rise = wr_lvl & ~wr_prev;
    assign rd_rise = rd_lvl & ~rd_prev;
    assign rt_act  = ~rt_lvl;

    // Next-state and pointer arithmetic
    always_comb begin
        do_wr = wr_rise && (st != ST_FULL);
        do_rd = rd_rise && (st != ST_EMPTY) && !rt_act;
        wp_n  = do_wr ? wp + 1'b1 : wp;
        rp_n  = rt_act ? '0 : (do_rd ? rp + 1'b1 : rp);
        unique case ({do_wr, do_rd})
            2'b10:   cnt_n = cnt + 1'b1;
            2'b01:   cnt_n = cnt - 1'b1;
            default: cnt_n = cnt;
        endcase
        if (rt_act && (cnt_n != FULL_CNT)) cnt_n = {1'b0, wp_n};

        unique case (st)
            ST_EMPTY: st_n = (cnt_n != '0) ? ST_HOLD : ST_EMPTY;
            ST_HOLD: begin
                if (cnt_n == '0)           st_n = ST_EMPTY;
                else if (cnt_n == FULL_CNT) st_n = ST_FULL;
                else                        st_n = ST_HOLD;
            end
            ST_FULL:  st_n = (cnt_n != FULL_CNT) ? ST_HOLD : ST_FULL;
            default:  st_n = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_EMPTY;
            cnt     <= '0;
            wp      <= '0;
            rp      <= '0;
            wr_prev <= 1'b1;
            rd_prev <= 1'b1;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            wp      <= wp_n;
            rp      <= rp_n;
            wr_prev <= wr_lvl;
            rd_prev <= rd_lvl;
        end
    end

    // Outputs
    always_comb begin
        we       = do_wr;
        waddr    = wp;
        raddr    = rp;
        empty_n  = (st != ST_EMPTY);
        full_n   = (st != ST_FULL);
        half_n   = !(cnt > HALF_CNT);
        dout_vld = !rd_lvl && (st != ST_EMPTY);
    end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DEPTH       = 256,
    parameter int WIDTH       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_n,
    input  logic             rt_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_vld,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);
    localparam int AW   = $clog2(DEPTH);
    localparam int NSTB = 3;

    logic [NSTB-1:0] pins, lvls;
    logic            we;
    logic [AW-1:0]   waddr, raddr;

    assign pins = {rt_n, rd_n, wr_n};

    for (genvar g = 0; g < NSTB; g++) begin : g_sync
        strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[g]),
            .level (lvls[g])
        );
    end

    fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lvl   (lvls[0]),
        .rd_lvl   (lvls[1]),
        .rt_lvl   (lvls[2]),
        .we       (we),
        .waddr    (waddr),
        .raddr    (raddr),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n),
        .dout_vld (dout_vld)
    );

    fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (dout)
    );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_rise,
    input logic rd_rise,
    input logic rt_act,
    input logic empty_n,
    input logic full_n,
    input logic half_n,
    input logic dout_vld
);
    a_r1_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && full_n && half_n && !dout_vld));

    a_r7_full_not_next_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> empty_n);

    a_r4_empty_not_next_full: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> full_n);

    a_r6_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);

    a_r8_vld_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> empty_n);

    a_r12_quiet_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rise && !rd_rise && !rt_act) |=>
            ($stable(empty_n) && $stable(full_n) && $stable(half_n)));
endmodule

bind fifo_ctrl strobe_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_rise  (wr_rise),
    .rd_rise  (rd_rise),
    .rt_act   (rt_act),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .half_n   (half_n),
    .dout_vld (dout_vld)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_vld, empty_n, full_n, half_n;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .rd_n(rd_n),
        .rt_n(rt_n), .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n)
    );

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 11) % 512);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic wr_word(input logic [8:0] d);
        din = d; wr_n = 1'b0;
        idle(3);
        wr_n = 1'b1;
        idle(4);
    endtask

    task automatic rd_word(output logic [8:0] d, output logic v);
        rd_n = 1'b0;
        idle(3);
        d = dout; v = dout_vld;
        rd_n = 1'b1;
        idle(4);
    endtask

    task automatic rd_expect(input logic [8:0] e, input string tag);
        logic [8:0] d;
        logic v;
        rd_word(d, v);
        chk(v && d == e, tag, int'({v, d}), int'({1'b1, e}));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk(!empty_n && full_n && half_n && !dout_vld, "R1 reset flags",
            int'({empty_n, full_n, half_n, dout_vld}), 4'b0110);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 5; i++) wr_word(pat(i));
        chk(empty_n, "R2 write clears empty", int'(empty_n), 1);
        for (int i = 0; i < 5; i++) rd_expect(pat(i), "R3 order");
        chk(!empty_n, "R4 empty after drain", int'(empty_n), 0);
    endtask

    task automatic t_empty_read();
        logic [8:0] d;
        logic v;
        do_reset();
        rd_word(d, v);
        chk(!v && !empty_n, "R4 read on empty ignored", int'({v, empty_n}), 0);
        wr_word(9'h055);
        rd_expect(9'h055, "R4 first word after empty read");
        chk(!empty_n, "R4 empty again", int'(empty_n), 0);
    endtask

    task automatic t_flow_read();
        do_reset();
        rd_n = 1'b0;
        idle(3);
        chk(!dout_vld, "R8 no valid while empty", int'(dout_vld), 0);
        wr_word(9'h1A5);
        chk(dout_vld && dout == 9'h1A5 && empty_n, "R9 flow-through word",
            int'({dout_vld, empty_n, dout}), int'({2'b11, 9'h1A5}));
        rd_n = 1'b1;
        idle(4);
        chk(!empty_n && !dout_vld, "R9 empty after flow read",
            int'({empty_n, dout_vld}), 0);
    endtask

    task automatic t_fill_and_flow_write();
        do_reset();
        for (int i = 0; i < DEPTH / 2; i++) wr_word(pat(i));
        chk(half_n, "R6 half_n high at DEPTH/2", int'(half_n), 1);
        wr_word(pat(DEPTH / 2));
        chk(!half_n, "R6 half_n low at DEPTH/2+1", int'(half_n), 0);
        for (int i = DEPTH / 2 + 1; i < DEPTH - 1; i++) wr_word(pat(i));
        chk(full_n, "R7 not full at DEPTH-1", int'(full_n), 1);
        wr_word(pat(DEPTH - 1));
        chk(!full_n, "R7 full at DEPTH", int'(full_n), 0);
        wr_word(9'h1FF);
        chk(!full_n, "R5 write on full ignored", int'(full_n), 0);
        din = 9'h123; wr_n = 1'b0;
        idle(3);
        rd_expect(pat(0), "R10 read from full");
        chk(full_n, "R10 full released while W held", int'(full_n), 1);
        wr_n = 1'b1;
        idle(4);
        chk(!full_n, "R10 held write completes", int'(full_n), 0);
        for (int i = 1; i < DEPTH; i++) rd_expect(pat(i), "R5 stored words intact");
        rd_expect(9'h123, "R10 held word last");
        chk(!empty_n, "R5 no extra word", int'(empty_n), 0);
    endtask

    task automatic t_simul();
        do_reset();
        for (int i = 0; i <= DEPTH / 2; i++) wr_word(pat(300 + i));
        din = 9'h0F0; wr_n = 1'b0; rd_n = 1'b0;
        idle(3);
        wr_n = 1'b1; rd_n = 1'b1;
        idle(4);
        chk(!half_n && empty_n, "R12 count unchanged", int'({half_n, empty_n}), 1);
        for (int i = 1; i <= DEPTH / 2; i++) rd_expect(pat(300 + i), "R12 order after simul");
        rd_expect(9'h0F0, "R12 simul word stored");
        chk(!empty_n, "R12 empty at end", int'(empty_n), 0);
    endtask

    task automatic t_retx();
        do_reset();
        for (int i = 0; i < 3; i++) wr_word(pat(500 + i));
        rd_expect(pat(500), "R11 pre read 0");
        rd_expect(pat(501), "R11 pre read 1");
        rt_n = 1'b0;
        idle(3);
        rt_n = 1'b1;
        idle(4);
        for (int i = 0; i < 3; i++) rd_expect(pat(500 + i), "R11 reread");
        chk(!empty_n, "R11 empty after reread", int'(empty_n), 0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_flow_read();
        t_fill_and_flow_write();
        t_simul();
        t_retx();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule